// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block generates the column addresses for one read or write burst in a DDR-style memory. A start strobe supplies a start column, a two-bit burst length code and an ordering select. The block then presents one column address per clock cycle with a valid flag, and it raises a last flag on the final beat.

Only the offset bits inside the burst-aligned block are reordered. These are bit 0 for two beats, bits 1:0 for four beats and bits 2:0 for eight beats. All column bits above that field come unchanged from the start column.

There are two orderings. Sequential ordering counts upward and wraps modulo the burst length. Interleaved ordering XORs the start offset with the beat index. A controller pulses the start input while the block is idle and takes addresses whenever the valid flag is high.

Top module: `burst_col_seq`

## Requirements
- R1: While reset is high, and in the first cycle after it, `valid_o`, `last_o` and `busy_o` are 0. Reset is synchronous and active high.
- R2: A start with length code 2'b00 is rejected. No beat follows it, and the block stays idle.
- R3: A start with code 2'b01 (2 beats), 2'b10 (4 beats) or 2'b11 (8 beats), taken while idle, is followed from the next cycle by exactly that many consecutive cycles with `valid_o` high. `valid_o` is low in the cycle after the last beat.
- R4: With `ileave_i`=0 (sequential), the offset of beat n is (s + n) mod L. Here L is the burst length and s is the start column's low log2(L) bits. For example, L=8 with s=5 gives 5,6,7,0,1,2,3,4.
- R5: With `ileave_i`=1 (interleaved), the offset of beat n is s XOR n. For example, L=8 with s=5 gives 5,4,7,6,1,0,3,2, and L=4 with s=3 gives 3,2,1,0.
- R6: The column bits above the burst offset field equal those of the start column on every beat and stay constant for the whole burst.
- R7: `last_o` is high on the final beat of a burst and on no other cycle.
- R8: A start asserted while a burst is running is ignored. The running sequence continues unchanged, and no extra beats follow.
- R9: For length 2, both orderings give the same sequence: 0,1 from an even start and 1,0 from an odd start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Burst start strobe |
| start_col_i | input | COL_W | Start column address |
| blen_i | input | 2 | Length code: 01=2, 10=4, 11=8, 00 rejected |
| ileave_i | input | 1 | 0 sequential, 1 interleaved |
| busy_o | output | 1 | A burst is in progress |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | `col_o` holds a beat |
| last_o | output | 1 | Current beat is the final one |

## Verification
The bench builds the block with the default `COL_W` of 10. This leaves seven column bits above the widest offset field, so the bench can give them distinctive patterns and check for corruption or leakage between the offset field and the pass-through bits at every length.

The bench drives all three lengths in both orderings from several starting offsets, including the odd offsets that make the two orderings diverge. It also sends a rejected length code, and it pulses the start input in the middle of a burst with conflicting parameters.

// File: rtl/burst_col_seq.sv
module burst_col_seq #(
  parameter int COL_W = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [COL_W-1:0] start_col_i,
  input  logic [1:0]       blen_i,
  input  logic             ileave_i,
  output logic             busy_o,
  output logic [COL_W-1:0] col_o,
  output logic             valid_o,
  output logic             last_o
);
  localparam int OFF_W = 3;

  logic             active_q;
  logic             ilv_q;
  logic [OFF_W-1:0] cnt_q;
  logic [OFF_W-1:0] soff_q;
  logic [OFF_W-1:0] mask_q;
  logic [COL_W-1:0] base_q;
  logic [OFF_W-1:0] mask_in;
  logic [OFF_W-1:0] off;
  logic             take;

  always_comb begin
    case (blen_i)
      2'b01:   mask_in = 3'b001;
      2'b10:   mask_in = 3'b011;
      2'b11:   mask_in = 3'b111;
      default: mask_in = 3'b000;
    endcase
  end

  assign take = start_i && !active_q && (blen_i != 2'b00);

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      ilv_q    <= 1'b0;
      cnt_q    <= '0;
      soff_q   <= '0;
      mask_q   <= '0;
      base_q   <= '0;
    end else if (take) begin
      active_q <= 1'b1;
      ilv_q    <= ileave_i;
      cnt_q    <= '0;
      soff_q   <= start_col_i[OFF_W-1:0] & mask_in;
      mask_q   <= mask_in;
      base_q   <= start_col_i;
    end else if (active_q) begin
      if (cnt_q == mask_q) active_q <= 1'b0;
      else                 cnt_q    <= cnt_q + 1'b1;
    end
  end

  assign off     = ilv_q ? (soff_q ^ cnt_q) : ((soff_q + cnt_q) & mask_q);
  assign col_o   = {base_q[COL_W-1:OFF_W], (base_q[OFF_W-1:0] & ~mask_q) | (off & mask_q)};
  assign valid_o = active_q;
  assign busy_o  = active_q;
  assign last_o  = active_q && (cnt_q == mask_q);
endmodule

// File: rtl/burst_col_seq_chk.sv
module burst_col_seq_chk #(
  parameter int COL_W = 10
) (
  input logic             clk,
  input logic             rst,
  input logic             start_i,
  input logic [COL_W-1:0] start_col_i,
  input logic [1:0]       blen_i,
  input logic             ileave_i,
  input logic             busy_o,
  input logic [COL_W-1:0] col_o,
  input logic             valid_o,
  input logic             last_o
);
  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> !valid_o && !last_o && !busy_o); // R1
  AST_BAD_CODE: assert property (@(posedge clk) disable iff (rst) (start_i && !busy_o && blen_i == 2'b00) |=> !valid_o); // R2
  AST_GOOD_START: assert property (@(posedge clk) disable iff (rst) (start_i && !busy_o && blen_i != 2'b00) |=> valid_o); // R3
  AST_END_AFTER_LAST: assert property (@(posedge clk) disable iff (rst) last_o |=> !valid_o); // R3
  AST_HIGH_STABLE: assert property (@(posedge clk) disable iff (rst) (valid_o && !last_o) |=> $stable(col_o[COL_W-1:3])); // R6
  AST_LAST_IN_BURST: assert property (@(posedge clk) disable iff (rst) last_o |-> valid_o); // R7
  AST_NO_RESTART: assert property (@(posedge clk) disable iff (rst) (valid_o && !last_o) |=> valid_o); // R8
endmodule

bind burst_col_seq burst_col_seq_chk #(.COL_W(COL_W)) u_chk (.*);

// File: tb/burst_col_seq_test.sv
module burst_col_seq_test;
  localparam int COL_W = 10;

  logic             clk = 1'b0;
  logic             rst;
  logic             start_i;
  logic [COL_W-1:0] start_col_i;
  logic [1:0]       blen_i;
  logic             ileave_i;
  logic             busy_o;
  logic [COL_W-1:0] col_o;
  logic             valid_o;
  logic             last_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [COL_W:0] exp_q[$];
  string          tag_q[$];

  always #2 clk = ~clk;

  burst_col_seq #(.COL_W(COL_W)) uut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic burst(input logic [COL_W-1:0] c, input logic [1:0] code, input logic il, input string req);
    int len;
    int s;
    int o;
    len = (code == 2'b01) ? 2 : (code == 2'b10) ? 4 : 8;
    s = int'(c) % len;
    for (int n = 0; n < len; n++) begin
      o = il ? (s ^ n) : ((s + n) % len);
      exp_q.push_back({n == len - 1, (c & ~COL_W'(len - 1)) | COL_W'(o)});
      tag_q.push_back(req);
    end
    @(negedge clk);
    start_i = 1'b1; start_col_i = c; blen_i = code; ileave_i = il;
    @(negedge clk);
    start_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (!rst && valid_o) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R3/R8 unexpected beat", int'(col_o), 0);
      end else begin
        logic [COL_W:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(col_o == e[COL_W-1:0], t, int'(col_o), int'(e[COL_W-1:0]));
        check(last_o == e[COL_W], "R7 last flag", int'(last_o), int'(e[COL_W]));
        check(busy_o, "R3 busy during beat", int'(busy_o), 1);
      end
    end else if (!rst) begin
      check(!last_o, "R7 last without beat", int'(last_o), 0);
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst = 1'b1; start_i = 1'b0; start_col_i = '0; blen_i = 2'b00; ileave_i = 1'b0;
    repeat (3) @(negedge clk);
    check(!valid_o && !last_o && !busy_o, "R1 reset state", int'({valid_o, last_o, busy_o}), 0);
    rst = 1'b0;
    @(negedge clk);
    check(!valid_o && !busy_o, "R1 after reset", int'({valid_o, busy_o}), 0);

    burst(10'h2A5, 2'b11, 1'b0, "R4 seq L8 s5");
    burst(10'h155, 2'b11, 1'b1, "R5 ilv L8 s5");
    burst(10'h0F3, 2'b10, 1'b0, "R4 seq L4 s3");
    burst(10'h3C3, 2'b10, 1'b1, "R5 ilv L4 s3");
    burst(10'h201, 2'b01, 1'b0, "R9 seq L2 odd");
    burst(10'h201, 2'b01, 1'b1, "R9 ilv L2 odd");
    burst(10'h1FE, 2'b01, 1'b1, "R9 ilv L2 even");
    burst(10'h3FF, 2'b11, 1'b1, "R6 high bits L8");
    burst(10'h2A8, 2'b11, 1'b0, "R6 high bits aligned");
    burst(10'h006, 2'b10, 1'b1, "R5 ilv L4 s2");

    @(negedge clk);
    start_i = 1'b1; start_col_i = 10'h155; blen_i = 2'b00; ileave_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    check(!valid_o && !busy_o, "R2 rejected code", int'({valid_o, busy_o}), 0);
    repeat (4) @(negedge clk);
    check(!valid_o, "R2 stays idle", int'(valid_o), 0);

    for (int i = 0; i < 8; i++) begin
      exp_q.push_back({i == 7, 10'h2E0 | 10'(6 ^ i)});
      tag_q.push_back("R8 running burst");
    end
    @(negedge clk);
    start_i = 1'b1; start_col_i = 10'h2E6; blen_i = 2'b11; ileave_i = 1'b1;
    @(negedge clk);
    start_col_i = 10'h011; blen_i = 2'b01; ileave_i = 1'b0;
    repeat (3) @(negedge clk);
    start_i = 1'b0;
    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    check(!valid_o, "R8 no extra beats", int'(valid_o), 0);
    check(exp_q.size() == 0, "R3 all beats seen", exp_q.size(), 0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule